// File: doc/BRIEF.md
# Recent Page Translation Micro-Cache

This block keeps a handful of the most recently used virtual-to-physical page translations close to a processor pipeline. A lookup can then skip the slower full translation path. It holds two independent arrays of equal depth. One serves instruction fetches and the other serves data accesses. Pages are 4 KiB. Each entry stores a virtual key, which is the virtual address shifted right by 12. It also stores a physical page base with the low 12 bits cleared, and a two-bit access code. Code 0 means the entry is empty, code 1 means it was filled by a read, and code 2 means it was filled by a write.

Filling is strictly in recency order. An insert writes slot 0 of the chosen array and pushes every older entry one slot deeper, so the deepest entry falls off the end. Lookup is combinational. It searches the chosen array for the shallowest valid entry whose key matches. It returns the physical address formed from the stored base and the low 12 bits of the lookup address, together with the access code and the slot that matched. A fill-disable input blocks all inserts, and a flush input empties both arrays in a single cycle.

Top module: `xlat_mru_cache`

## Requirements
- R1: After reset every entry in both arrays is empty, so every lookup misses, including a lookup of virtual address 0.
- R2: An insert with `ins_valid`=1 writes slot 0 of the instruction array when `ins_instr`=1, or of the data array when `ins_instr`=0. It stores code 2 when `ins_write`=1 and code 1 otherwise. The entry becomes visible to lookups after the next rising clock edge and not in the cycle of the insert.
- R3: Each insert moves the entry in slot k of the chosen array to slot k+1 for every k below DEPTH-1, and drops the entry in slot DEPTH-1. The other array is left unchanged.
- R4: A lookup searches the array selected by `lk_instr` (1 = instruction, 0 = data). It picks the lowest-numbered non-empty slot whose stored key equals `lk_vaddr >> 12`, and reports that slot number on `lk_slot` when there is a hit.
- R5: A read lookup (`lk_write`=0) hits when the picked entry holds code 1 or 2. A write lookup hits only when the picked entry holds code 2. A write lookup whose picked entry holds code 1 misses, even if a deeper slot holds the same page with code 2.
- R6: On a hit, `lk_paddr` equals the stored base, which is the inserted physical address with its low 12 bits cleared, ORed with bits 11:0 of `lk_vaddr`. `lk_perm` gives the entry's code.
- R7: On a miss, `lk_hit`, `lk_paddr`, `lk_perm` and `lk_slot` are all zero.
- R8: While `fill_disable`=1 an insert request changes no entry.
- R9: `flush`=1 empties both arrays at the next clock edge. It takes priority over an insert in the same cycle, which is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empty both arrays |
| fill_disable | input | 1 | Block all inserts |
| ins_valid | input | 1 | Insert request |
| ins_instr | input | 1 | Insert target: 1 instruction array, 0 data array |
| ins_write | input | 1 | Translation was filled by a write |
| ins_vaddr | input | VA_W | Virtual address of the new translation |
| ins_paddr | input | PA_W | Physical address of the new translation |
| lk_instr | input | 1 | Lookup array: 1 instruction, 0 data |
| lk_write | input | 1 | Lookup is for a write access |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_hit | output | 1 | Translation found with sufficient permission |
| lk_paddr | output | PA_W | Translated physical address, zero on miss |
| lk_perm | output | 2 | Access code of the hit entry, zero on miss |
| lk_slot | output | SLOT_W | Slot that hit, zero on miss |

## Verification
Lookup results are combinational. The bench therefore compares `lk_hit`, `lk_paddr`, `lk_perm` and `lk_slot` in the same low half-cycle in which the lookup inputs are driven, against a model that still holds the contents from before the coming edge. Inserts, flushes and the fill-disable gate act at the rising edge. The bench applies them to its model only after that edge, so their effect is first compared one cycle after the request. Directed cases place a lookup of the page being inserted in the insert's own cycle, where it must still miss, and again in the next cycle, where it must hit.

// File: rtl/xlat_mru_cache.sv
module xlat_mru_cache #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  parameter int DEPTH = 4,
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              fill_disable,
  input  logic              ins_valid,
  input  logic              ins_instr,
  input  logic              ins_write,
  input  logic [VA_W-1:0]   ins_vaddr,
  input  logic [PA_W-1:0]   ins_paddr,
  input  logic              lk_instr,
  input  logic              lk_write,
  input  logic [VA_W-1:0]   lk_vaddr,
  output logic              lk_hit,
  output logic [PA_W-1:0]   lk_paddr,
  output logic [1:0]        lk_perm,
  output logic [SLOT_W-1:0] lk_slot
);

  localparam logic [PA_W-1:0] OFF_MASK = PA_W'((64'd1 << OFF_W) - 64'd1);
  localparam logic [1:0] CODE_RD = 2'd1;
  localparam logic [1:0] CODE_WR = 2'd2;

  // index 1 = instruction array, index 0 = data array
  logic [1:0][DEPTH-1:0][VA_W-1:0] key_q;
  logic [1:0][DEPTH-1:0][PA_W-1:0] base_q;
  logic [1:0][DEPTH-1:0][1:0]      code_q;

  logic            do_fill;
  logic [VA_W-1:0] ins_key, lk_key;
  logic [PA_W-1:0] ins_base;

  assign do_fill  = ins_valid && !fill_disable && !flush;
  assign ins_key  = ins_vaddr >> OFF_W;
  assign ins_base = ins_paddr & ~OFF_MASK;
  assign lk_key   = lk_vaddr >> OFF_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      base_q <= '0;
      code_q <= '0;
    end else if (flush) begin
      code_q <= '0;
    end else if (do_fill) begin
      for (int k = DEPTH - 1; k > 0; k--) begin
        key_q[ins_instr][k]  <= key_q[ins_instr][k-1];
        base_q[ins_instr][k] <= base_q[ins_instr][k-1];
        code_q[ins_instr][k] <= code_q[ins_instr][k-1];
      end
      key_q[ins_instr][0]  <= ins_key;
      base_q[ins_instr][0] <= ins_base;
      code_q[ins_instr][0] <= ins_write ? CODE_WR : CODE_RD;
    end
  end

  logic              found;
  logic [SLOT_W-1:0] pick;
  logic [1:0]        pick_code;
  logic [PA_W-1:0]   pick_base;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (code_q[lk_instr][k] != 2'd0 && key_q[lk_instr][k] == lk_key) begin
        found = 1'b1;
        pick  = SLOT_W'(k);
      end
    end
  end

  assign pick_code = code_q[lk_instr][pick];
  assign pick_base = base_q[lk_instr][pick];

  assign lk_hit   = found && (!lk_write || pick_code == CODE_WR);
  assign lk_paddr = lk_hit ? (pick_base | (PA_W'(lk_vaddr) & OFF_MASK)) : '0;
  assign lk_perm  = lk_hit ? pick_code : 2'd0;
  assign lk_slot  = lk_hit ? pick : '0;

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (code_q == '0));

  assert_blocked_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_disable && !flush) |=> ($stable(code_q) && $stable(key_q) && $stable(base_q)));

  assert_head_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !fill_disable && !flush) |=>
      (key_q[$past(ins_instr)][0] == ($past(ins_vaddr) >> OFF_W)) &&
      (code_q[$past(ins_instr)][0] == ($past(ins_write) ? CODE_WR : CODE_RD)));

  assert_shift_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !fill_disable && !flush) |=>
      (key_q[$past(ins_instr)][DEPTH-1:1] == $past(key_q[ins_instr][DEPTH-2:0])) &&
      (code_q[$past(ins_instr)][DEPTH-1:1] == $past(code_q[ins_instr][DEPTH-2:0])));

  assert_other_side_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !fill_disable && !flush) |=>
      (code_q[!$past(ins_instr)] == $past(code_q[!ins_instr])) &&
      (key_q[!$past(ins_instr)] == $past(key_q[!ins_instr])));

  assert_write_needs_code2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_write) |-> (lk_perm == CODE_WR));

  assert_miss_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_paddr == '0 && lk_perm == 2'd0 && lk_slot == '0));

endmodule

// File: tb/xlat_mru_cache_bench.sv
module xlat_mru_cache_bench;
  localparam int VA_W = 32, PA_W = 32, OFF_W = 12, DEPTH = 4, SLOT_W = 2;

  logic clk = 0, rst_n = 0;
  logic flush = 0, fill_disable = 0, ins_valid = 0, ins_instr = 0, ins_write = 0;
  logic [VA_W-1:0] ins_vaddr = '0, lk_vaddr = '0;
  logic [PA_W-1:0] ins_paddr = '0;
  logic lk_instr = 0, lk_write = 0;
  logic lk_hit;
  logic [PA_W-1:0] lk_paddr;
  logic [1:0] lk_perm;
  logic [SLOT_W-1:0] lk_slot;

  xlat_mru_cache #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .DEPTH(DEPTH)) u_xlat_mru_cache (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fill_disable(fill_disable),
    .ins_valid(ins_valid), .ins_instr(ins_instr), .ins_write(ins_write),
    .ins_vaddr(ins_vaddr), .ins_paddr(ins_paddr),
    .lk_instr(lk_instr), .lk_write(lk_write), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_perm(lk_perm), .lk_slot(lk_slot));

  always #10 clk = ~clk;

  int compared = 0, mismatched = 0;
  logic [VA_W-1:0] m_key  [2][DEPTH];
  logic [PA_W-1:0] m_base [2][DEPTH];
  logic [1:0]      m_code [2][DEPTH];

  task automatic cmp(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int a = 0; a < 2; a++)
      for (int k = 0; k < DEPTH; k++) begin
        m_key[a][k] = '0; m_base[a][k] = '0; m_code[a][k] = 2'd0;
      end
  endtask

  // lookup check against model contents before the coming edge
  task automatic check_lookup(string tag);
    int a, sel;
    logic hit;
    a = lk_instr ? 1 : 0;
    sel = -1;
    for (int k = DEPTH - 1; k >= 0; k--)
      if (m_code[a][k] != 0 && m_key[a][k] == (lk_vaddr >> OFF_W)) sel = k;
    hit = (sel >= 0) && (!lk_write || m_code[a][sel] == 2'd2);
    cmp({tag, " R5 hit"}, 64'(lk_hit), 64'(hit));
    if (hit) begin
      cmp({tag, " R6 paddr"}, 64'(lk_paddr),
          64'((m_base[a][sel] & ~PA_W'(32'hfff)) | PA_W'(lk_vaddr[OFF_W-1:0])));
      cmp({tag, " R6 perm"}, 64'(lk_perm), 64'(m_code[a][sel]));
      cmp({tag, " R4 slot"}, 64'(lk_slot), 64'(sel));
    end else begin
      cmp({tag, " R7 quiet"}, {lk_paddr, 28'd0, lk_perm, 2'(lk_slot)}, 64'd0);
    end
  endtask

  task automatic step(string tag, bit fl, bit dis, bit iv, bit ii, bit iw,
                      logic [VA_W-1:0] iva, logic [PA_W-1:0] ipa,
                      bit li, bit lw, logic [VA_W-1:0] lva);
    flush = fl; fill_disable = dis; ins_valid = iv; ins_instr = ii; ins_write = iw;
    ins_vaddr = iva; ins_paddr = ipa; lk_instr = li; lk_write = lw; lk_vaddr = lva;
    #5;
    check_lookup(tag);
    @(posedge clk);
    if (fl) model_clear();
    else if (iv && !dis) begin
      int a;
      a = ii ? 1 : 0;
      for (int k = DEPTH - 1; k > 0; k--) begin
        m_key[a][k] = m_key[a][k-1]; m_base[a][k] = m_base[a][k-1]; m_code[a][k] = m_code[a][k-1];
      end
      m_key[a][0] = iva >> OFF_W; m_base[a][0] = ipa & ~PA_W'(32'hfff);
      m_code[a][0] = iw ? 2'd2 : 2'd1;
    end
    @(negedge clk);
  endtask

  task automatic look(string tag, bit li, bit lw, logic [VA_W-1:0] lva);
    step(tag, 0, 0, 0, 0, 0, '0, '0, li, lw, lva);
  endtask

  task automatic put(string tag, bit ii, bit iw, logic [VA_W-1:0] iva, logic [PA_W-1:0] ipa);
    step(tag, 0, 0, 1, ii, iw, iva, ipa, ii, 0, iva);
  endtask

  bit done = 0;
  initial begin
    #(20 * 200000);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_1234);
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: empty after reset
    look("R1 va0 data", 0, 0, 32'h0);
    look("R1 va0 instr", 1, 0, 32'h0);
    look("R1 rand", 1, 1, 32'h1234_5678);

    // R2: same-cycle miss, next-cycle hit, array choice
    put("R2 same cycle", 0, 0, 32'h0000_5abc, 32'h8765_4fff);
    look("R2 next cycle", 0, 0, 32'h0000_5123);
    look("R2 other array", 1, 0, 32'h0000_5123);
    put("R2 instr write", 1, 1, 32'h0009_9000, 32'h0001_2000);
    look("R2 instr hit", 1, 1, 32'h0009_9ffe);

    // R3: eviction past the deepest slot
    for (int i = 0; i < 5; i++) put("R3 fill", 1, 0, VA_W'((i + 16) << 12), PA_W'((i + 48) << 12));
    for (int i = 0; i < 5; i++) look("R3 probe", 1, 0, VA_W'(((i + 16) << 12) | 12'h0a4));
    look("R3 data kept", 0, 0, 32'h0000_5010);

    // R5: write lookup does not fall through to deeper code-2 entry
    put("R5 wr", 0, 1, 32'h0077_7000, 32'h00aa_a000);
    put("R5 rd", 0, 0, 32'h0077_7000, 32'h00bb_b000);
    look("R5 write blocked", 0, 1, 32'h0077_7044);
    look("R5 read slot0", 0, 0, 32'h0077_7044);

    // R8: fill disable
    step("R8 blocked", 0, 1, 1, 0, 1, 32'h0066_6000, 32'h0011_1000, 0, 0, 32'h0066_6000);
    look("R8 still miss", 0, 0, 32'h0066_6000);

    // R9: flush beats insert, both arrays empty
    step("R9 flush", 1, 0, 1, 1, 0, 32'h0044_4000, 32'h0022_2000, 1, 0, 32'h0009_9000);
    look("R9 instr empty", 1, 0, 32'h0044_4000);
    look("R9 data empty", 0, 0, 32'h0077_7000);

    // random mix over a small page pool
    for (int n = 0; n < 4000; n++) begin
      int r;
      bit fl, dis, iv, ii, iw, li, lw;
      logic [VA_W-1:0] iva, lva;
      logic [PA_W-1:0] ipa;
      r = $urandom_range(0, 99);
      fl = (r < 2); dis = (r >= 2 && r < 10);
      iv = $urandom_range(0, 1); ii = $urandom_range(0, 1); iw = $urandom_range(0, 1);
      li = $urandom_range(0, 1); lw = $urandom_range(0, 1);
      iva = VA_W'(($urandom_range(0, 7) << 12) | $urandom_range(0, 4095));
      ipa = PA_W'($urandom);
      lva = VA_W'(($urandom_range(0, 7) << 12) | $urandom_range(0, 4095));
      step("rand", fl, dis, iv, ii, iw, iva, ipa, li, lw, lva);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule